// File: doc/BRIEF.md
# HDLC Transmit Framer with Tagged Command Queue

This block turns a queue of tagged bytes into a serial HDLC-style bit stream. A host pushes 10-bit words into a small internal queue. The upper two bits of each word tell the framer what to do with the low byte. It can send the byte as stuffed payload and fold it into the frame checksum. It can drop the written value and send the next byte of the running checksum in its place. Or it can send the byte verbatim with no stuffing, which is how opening and closing flags and abort patterns reach the line.

Serialization advances only on cycles where the bit-clock enable is high. Each such cycle moves exactly one bit to the output register. After every five consecutive ones inside stuffed content, the framer inserts a zero and no payload bit moves in that slot. If the queue has nothing to offer when the next byte is due, the framer raises an underrun indication and holds the line at one until a word arrives.

Top module: `txf_hdlc_framer`

## Requirements
- R1: A word tagged 2'b00 is a payload byte: it is sent with zero insertion and folded into the checksum. Tag 2'b10 is reserved and behaves the same way.
- R2: A word tagged 2'b01 is a checksum slot. Its low byte is ignored. It is replaced by the next byte of the complemented checksum, starting with the least significant byte. The byte index advances by one per slot and wraps after two slots (16-bit mode) or four slots (32-bit mode).
- R3: A word tagged 2'b11 is sent verbatim with no zero insertion. It presets the checksum to all ones, clears the ones-run count and resets the checksum-slot index to the least significant byte.
- R4: In stuffed content, a 0 bit is sent right after every fifth consecutive 1. The run may span byte boundaries. The inserted zero restarts the count. The inserted zero is sent even if the next byte is verbatim.
- R5: Every byte is sent least significant bit first.
- R6: With `crc32_sel` low, the checksum is the reflected 16-bit CCITT code: polynomial 0x8408 in reflected form, preset 0xFFFF. For the ASCII string "123456789", its complement is 0x906E.
- R7: With `crc32_sel` high, the checksum is the reflected 32-bit code: polynomial 0xEDB88320, preset all ones. For "123456789", its complement is 0xCBF43926.
- R8: If a new byte is due on an enabled cycle and the queue is empty, `underrun` goes high and the line sends 1. Both stay that way until the cycle that takes the next word from the queue.
- R9: `tx_bit` and `underrun` change only on the clock edge of a cycle where `bit_en` is high. After reset, `tx_bit` is 1 and `underrun` is 0.
- R10: The queue holds FIFO_DEPTH words (4 by default). `fifo_full` is high when it holds that many. A write while full is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 10 | Tag in [9:8], byte in [7:0] |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH words |
| crc32_sel | input | 1 | 1 selects the 32-bit checksum, 0 the 16-bit one |
| bit_en | input | 1 | Bit-clock enable, one output bit per high cycle |
| tx_bit | output | 1 | Serial line output |
| underrun | output | 1 | Queue was empty when a byte was due |

## Verification
The check-value string "123456789" is sent in both checksum widths, so a wrong polynomial, preset, final complement or byte order changes the checksum slots. A frame of long ones runs across byte edges separates correct zero insertion from a count that restarts per byte or forgets the inserted zero. Verbatim flags and abort bytes interleaved with payload show that stuffing and checksum state are cleared. A queue filled while the enable is held low, a write while full, and a gap in the middle of a frame cover the dropped write and the underrun idle. The enable is pulsed every cycle and every second and third cycle, so output holding between enables is exercised.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 2;
  localparam int WORD_W = CMD_W + BYTE_W;
  localparam int CRC_W  = 32;

  typedef enum logic [CMD_W-1:0] {
    CMD_DATA = 2'b00,
    CMD_FCS  = 2'b01,
    CMD_RSVD = 2'b10,
    CMD_RAW  = 2'b11
  } cmd_e;

  localparam logic [CRC_W-1:0] POLY16     = 32'h0000_8408;
  localparam logic [CRC_W-1:0] POLY32     = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_PRESET = '1;

  // Reflected checksum over one byte, bit 0 of the byte first.
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d,
                                                input logic wide);
    logic [CRC_W-1:0] r;
    logic fb;
    r = wide ? c : {16'h0000, c[15:0]};
    for (int i = 0; i < BYTE_W; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ (wide ? POLY32 : POLY16);
    end
    return r;
  endfunction
endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push_ok) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (pop_ok)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    if (push_ok && !pop_ok)      cnt_d = cnt_q + CW'(1);
    else if (pop_ok && !push_ok) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wp_q] <= din;
  end
endmodule

// File: rtl/txf_crc.sv
module txf_crc
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              upd,
  input  logic [BYTE_W-1:0] data,
  input  logic              wide,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)     crc_d = CRC_PRESET;
    else if (upd) crc_d = crc_byte(crc_q, data, wide);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_PRESET;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/txf_hdlc_framer.sv
module txf_hdlc_framer
  import txf_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int STUFF_RUN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              fifo_full,
  input  logic              crc32_sel,
  input  logic              bit_en,
  output logic              tx_bit,
  output logic              underrun
);
  localparam int RUN_W  = $clog2(STUFF_RUN + 1);
  localparam int LEFT_W = $clog2(BYTE_W + 1);

  logic [WORD_W-1:0] head;
  logic              fifo_empty;
  logic              pop;
  logic              crc_init, crc_upd;
  logic [CRC_W-1:0]  crc_q;
  cmd_e              cmd;
  logic [BYTE_W-1:0] payload, fcs_byte;

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              raw_q, raw_d;
  logic [RUN_W-1:0]  ones_q, ones_d;
  logic [1:0]        idx_q, idx_d;
  logic              bit_q, bit_d;
  logic              urun_q, urun_d;

  txf_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data),
    .pop(pop), .dout(head), .empty(fifo_empty), .full(fifo_full)
  );

  txf_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
    .data(payload), .wide(crc32_sel), .crc(crc_q)
  );

  assign cmd     = cmd_e'(head[WORD_W-1:BYTE_W]);
  assign payload = head[BYTE_W-1:0];

  always_comb begin
    case (idx_q)
      2'd0:    fcs_byte = ~crc_q[7:0];
      2'd1:    fcs_byte = ~crc_q[15:8];
      2'd2:    fcs_byte = ~crc_q[23:16];
      default: fcs_byte = ~crc_q[31:24];
    endcase
  end

  always_comb begin
    logic              have;
    logic [BYTE_W-1:0] sh_v;
    logic [LEFT_W-1:0] left_v;
    logic              raw_v;
    sh_d     = sh_q;
    left_d   = left_q;
    raw_d    = raw_q;
    ones_d   = ones_q;
    idx_d    = idx_q;
    bit_d    = bit_q;
    urun_d   = urun_q;
    pop      = 1'b0;
    crc_init = 1'b0;
    crc_upd  = 1'b0;
    have     = (left_q != '0);
    sh_v     = sh_q;
    left_v   = left_q;
    raw_v    = raw_q;
    if (bit_en) begin
      if (ones_q == RUN_W'(STUFF_RUN)) begin
        bit_d  = 1'b0;
        ones_d = '0;
      end else begin
        if (!have && !fifo_empty) begin
          pop    = 1'b1;
          urun_d = 1'b0;
          left_v = LEFT_W'(BYTE_W);
          raw_v  = (cmd == CMD_RAW);
          have   = 1'b1;
          case (cmd)
            CMD_RAW: begin
              sh_v     = payload;
              crc_init = 1'b1;
              idx_d    = '0;
            end
            CMD_FCS: begin
              sh_v  = fcs_byte;
              idx_d = crc32_sel ? idx_q + 2'd1 : {1'b0, ~idx_q[0]};
            end
            default: begin
              sh_v    = payload;
              crc_upd = 1'b1;
            end
          endcase
        end
        if (have) begin
          bit_d  = sh_v[0];
          sh_d   = sh_v >> 1;
          left_d = left_v - LEFT_W'(1);
          raw_d  = raw_v;
          ones_d = (raw_v || !sh_v[0]) ? '0 : ones_q + RUN_W'(1);
        end else begin
          bit_d  = 1'b1;
          urun_d = 1'b1;
          ones_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      raw_q  <= 1'b0;
      ones_q <= '0;
      idx_q  <= '0;
      bit_q  <= 1'b1;
      urun_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      raw_q  <= raw_d;
      ones_q <= ones_d;
      idx_q  <= idx_d;
      bit_q  <= bit_d;
      urun_q <= urun_d;
    end
  end

  assign tx_bit   = bit_q;
  assign underrun = urun_q;
endmodule

// File: rtl/txf_hdlc_framer_chk.sv
module txf_hdlc_framer_chk #(
  parameter int STUFF_RUN = 5
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bit_en,
  input logic                           tx_bit,
  input logic                           underrun,
  input logic                           fifo_full,
  input logic                           fifo_empty,
  input logic [$clog2(STUFF_RUN+1)-1:0] ones
);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(tx_bit) && $stable(underrun)));

  assert_zero_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && ones == RUN_W'(STUFF_RUN)) |=> !tx_bit);

  assert_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_W'(STUFF_RUN));

  assert_idle_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> tx_bit);

  assert_underrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(fifo_empty));

  assert_full_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !bit_en) |=> fifo_full);
endmodule

bind txf_hdlc_framer txf_hdlc_framer_chk #(.STUFF_RUN(STUFF_RUN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bit(tx_bit),
  .underrun(underrun), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .ones(ones_q)
);

// File: tb/txf_hdlc_framer_test.sv
module txf_hdlc_framer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [9:0] wr_data;
  logic       fifo_full;
  logic       crc32_sel;
  logic       bit_en;
  logic       tx_bit;
  logic       underrun;

  int checks = 0;
  int failures = 0;
  string cur_req = "R9";

  int per_n = 2;
  int phase = 0;

  int       m_q[$];
  int       m_ones = 0, m_left = 0, m_sh = 0, m_idx = 0;
  bit       m_raw = 0;
  bit [31:0] m_crc = 32'hFFFF_FFFF;
  bit       m_bit = 1, m_urun = 0;

  always #2 clk = ~clk;

  txf_hdlc_framer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_full(fifo_full), .crc32_sel(crc32_sel), .bit_en(bit_en),
    .tx_bit(tx_bit), .underrun(underrun)
  );

  function automatic bit [31:0] crc_ref(bit [31:0] c, int b, bit wide);
    bit [31:0] r = wide ? c : (c & 32'h0000_FFFF);
    for (int i = 0; i < 8; i++) begin
      bit fb = r[0] ^ ((b >> i) & 1);
      r = r >> 1;
      if (fb) r = r ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
    end
    return r;
  endfunction

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    if (m_ones == 5) begin
      m_bit = 0; m_ones = 0;
    end else begin
      if (m_left == 0 && m_q.size() > 0) begin
        int w = m_q.pop_front();
        int c = (w >> 8) & 3;
        int b = w & 255;
        m_urun = 0; m_left = 8; m_raw = (c == 3);
        if (c == 3) begin
          m_sh = b; m_crc = 32'hFFFF_FFFF; m_idx = 0;
        end else if (c == 1) begin
          m_sh = int'(((~m_crc) >> (8 * m_idx)) & 32'hFF);
          m_idx = crc32_sel ? (m_idx + 1) % 4 : (m_idx + 1) % 2;
        end else begin
          m_sh = b; m_crc = crc_ref(m_crc, b, crc32_sel);
        end
      end
      if (m_left > 0) begin
        m_bit = m_sh[0]; m_sh = m_sh >> 1; m_left--;
        m_ones = m_raw ? 0 : (m_bit ? m_ones + 1 : 0);
      end else begin
        m_bit = 1; m_urun = 1; m_ones = 0;
      end
    end
  endtask

  task automatic cyc(input bit we, input int wd);
    bit fullnow;
    wr_en   = we;
    wr_data = 10'(wd);
    bit_en  = (per_n != 0) && (phase % per_n == 0);
    fullnow = fifo_full;
    @(negedge clk);
    if (bit_en) model_step();
    if (we && !fullnow) m_q.push_back(wd);
    phase++;
    checks++;
    if (tx_bit !== m_bit || underrun !== m_urun) begin
      failures++;
      $display("FAIL %s tx_bit/underrun actual=%0b/%0b expected=%0b/%0b",
               cur_req, tx_bit, underrun, m_bit, m_urun);
    end
  endtask

  task automatic put(input int cmd, input int b);
    while (fifo_full) cyc(0, 0);
    cyc(1, (cmd << 8) | b);
  endtask

  task automatic drain();
    while (m_q.size() > 0 || m_left > 0 || m_ones == 5) cyc(0, 0);
    for (int i = 0; i < 12; i++) cyc(0, 0);
  endtask

  task automatic send_check_string();
    string s = "123456789";
    for (int i = 0; i < 9; i++) put(0, int'(s[i]));
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit [31:0] c;
    string s = "123456789";
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; crc32_sel = 1'b0; bit_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", tx_bit, 1, "reset tx_bit");
    check("R9", underrun, 0, "reset underrun");
    check("R10", fifo_full, 0, "reset fifo_full");

    // Anchor the reference checksum to the published check values.
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 9; i++) c = crc_ref(c, int'(s[i]), 1'b0);
    check("R6", int'((~c) & 32'hFFFF), 'h906E, "crc16 check value");
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 9; i++) c = crc_ref(c, int'(s[i]), 1'b1);
    check("R7", int'(~c), int'(32'hCBF43926), "crc32 check value");

    // Idle with empty queue: underrun and ones
    cur_req = "R8";
    per_n = 3;
    for (int i = 0; i < 10; i++) cyc(0, 0);
    check("R8", underrun, 1, "idle underrun");

    // R6 / R5 / R1: 16-bit frame on check string
    cur_req = "R6";
    per_n = 2;
    put(3, 'h7E); send_check_string(); put(1, 'h00); put(1, 'h00); put(3, 'h7E);
    drain();

    // R4: long ones runs across bytes, placeholder values ignored (R2)
    cur_req = "R4";
    put(3, 'h7E); put(0, 'hFF); put(0, 'hFF); put(0, 'h3F); put(0, 'h1F);
    put(0, 'hF8); put(1, 'hFF); put(1, 'hA5); put(3, 'h7E);
    drain();

    // R3: verbatim abort byte, reserved tag as payload, flags
    cur_req = "R3";
    put(3, 'h7E); put(0, 'h7C); put(2, 'hFE); put(3, 'hFF); put(3, 'h7E);
    put(0, 'h1F); put(1, 'h00); put(1, 'h00); put(3, 'h7E);
    drain();

    // R7: 32-bit frame, four slots, enable every cycle
    cur_req = "R7";
    per_n = 1;
    crc32_sel = 1'b1;
    cyc(0, 0);
    put(3, 'h7E); send_check_string();
    put(1, 'h11); put(1, 'h22); put(1, 'h33); put(1, 'h44); put(3, 'h7E);
    drain();
    crc32_sel = 1'b0;

    // R10: fill with enable held low, write while full is dropped
    cur_req = "R10";
    per_n = 0;
    put(3, 'h7E); put(0, 'hA5); put(0, 'h3C); put(1, 'h00);
    check("R10", fifo_full, 1, "full after depth writes");
    cyc(1, 'h0C3);
    check("R10", fifo_full, 1, "still full after dropped write");
    per_n = 2;
    put(1, 'h00); put(3, 'h7E);
    drain();

    // R8: gap inside a frame
    cur_req = "R8";
    per_n = 1;
    put(3, 'h7E); put(0, 'h55);
    for (int i = 0; i < 40; i++) cyc(0, 0);
    check("R8", underrun, 1, "mid-frame underrun");
    check("R8", tx_bit, 1, "mid-frame idle level");
    cur_req = "R2";
    put(0, 'h0F); put(1, 'h00); put(1, 'h00); put(3, 'h7E);
    drain();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule